// File: doc/BRIEF.md
# Programmable Line Pulse Sequence Generator

This block drives two per-line timing pulses for an image-sensor front end: a clamp pulse that marks the optical-black pixels and a blanking pulse that marks the pixels to be blanked. The two pulses are generated in the same way from separate register sets. Each pulse has four programmable sequences. A sequence gives the level at which the line starts and up to two pixel positions where that level inverts.

A frame is divided into four vertical regions by line number. Each region has a two-bit pointer that picks one of the four sequences, so the shape of a pulse can change from one band of lines to the next. Software writes the registers through a plain address/data write strobe. The block keeps its own pixel counter, which restarts on the horizontal sync strobe, and its own line counter, which restarts on the vertical sync strobe.

The selected sequence and its positions are captured at each horizontal sync. A register write therefore never bends a line that is already in progress.

A line-phase state machine tracks each line. It has three states:
- `ST_IDLE`: from reset until the first horizontal sync. The pixel counter holds at 0 and the outputs hold their reset level.
- `ST_RUN`: the pixel counter advances and toggle positions are compared against it.
- `ST_OVERRUN`: entered once the pixel counter has saturated at 4095. The counter holds and no toggles occur.

The state machine makes three kinds of transition:
- `IDLE→RUN` (line start) on horizontal sync.
- `RUN→OVERRUN` (saturate) when the count is 4095 and no sync is present.
- `RUN→RUN` and `OVERRUN→RUN` (line restart) on horizontal sync.

Top module: `line_pulse_seq_gen`

## Requirements
- R1: After reset, both outputs are 1. Every polarity register resets to 0xF, every toggle register to 0xFFFFFF, every pointer register to 0, and every change position to 0xFFF. With these values a line shows a constant 1 on both outputs.
- R2: The clamp register set starts at base address 20 and the blanking set at base 30. Offsets from the base are as follows:
  - +0: polarity. Bit n is the starting level of sequence n.
  - +1 to +4: toggle registers for sequences 0 to 3. Bits [11:0] hold the first position and bits [23:12] the second.
  - +5: pointer. Region n uses bits [2n+1:2n].
  - +6 to +8: change positions of regions 1 to 3, in bits [11:0].
  - +9: the fixed region-0 position, which is always 0.
- R3: The pixel counter is cleared by the clock edge that samples horizontal sync high. It then increments on every clock and saturates at 4095. The output seen while the count is k includes every toggle whose position is less than k, so an inversion appears one clock after the count equals the position.
- R4: At each horizontal sync an output loads the starting level of the selected sequence. It then inverts at the first position and again at the second. When both positions are equal, the two inversions cancel and the level does not change.
- R5: A toggle position of 0xFFF never causes an inversion.
- R6: The line counter is set to 0 by vertical sync and increments, saturating at 4095, by horizontal sync. When both strobes arrive in the same cycle, vertical sync wins. A line's number is the counter value just after the horizontal sync that starts it.
- R7: The active region of a line is the highest-numbered region whose change position is less than or equal to the line number. Region 0 starts at line 0. When several change positions are equal, the highest region wins.
- R8: The pointer field of the active region selects which sequence drives that output for the whole line.
- R9: A register write made during a line has no effect on that line. It applies from the next horizontal sync.
- R10: A write to offset +9 of either set, or to any address outside both sets, changes no register and no output.
- R11: The clamp and blanking outputs are independent. Each uses only its own register set.
- R12: Before the first horizontal sync after reset, both outputs stay at 1 whatever is written. After the count saturates at 4095, an output holds its level until the next horizontal sync.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| hsync | input | 1 | Horizontal sync strobe, one clock wide, starts a line |
| vsync | input | 1 | Vertical sync strobe, one clock wide, restarts the line count |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address |
| wr_data | input | 24 | Register write data |
| clamp_pulse | output | 1 | Optical-black clamp pulse |
| blank_pulse | output | 1 | Pre-blanking pulse |

## Verification
The bench aims at the following corner cases and the failure each one exposes:
- Equal toggle positions must cancel. A design that gives one position priority leaves the line inverted.
- A position of 0xFFF must stay disabled. A design that compares it against the saturated counter inverts at the end of long lines.
- Two regions with the same change position must resolve to the higher region. A design that picks the first match selects the wrong sequence on those lines.
- When vertical and horizontal sync coincide, the line count must go to 0. A design that lets horizontal sync win numbers the first line 1 and picks the wrong region.
- A pointer written in mid-line must wait for the next line. A design that does not capture the sequence at the sync switches the waveform part-way through a line.
- A write to the fixed region-0 address must be dropped. A design that aliases it onto region 1 moves the first region boundary.

// File: rtl/lpsg_pkg.sv
package lpsg_pkg;

    // Phase of the current line as seen by the pixel counter
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RUN     = 2'd1,
        ST_OVERRUN = 2'd2
    } line_state_e;

endpackage

// File: rtl/lpsg_regfile.sv
module lpsg_regfile #(
    parameter int ADDR_W  = 6,
    parameter int DATA_W  = 24,
    parameter int POS_W   = 12,
    parameter int NSEQ    = 4,
    parameter int NREGION = 4,
    parameter int BASE    = 20
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic [ADDR_W-1:0]                    wr_addr,
    input  logic [DATA_W-1:0]                    wr_data,
    output logic [NSEQ-1:0]                      pol,
    output logic [NSEQ-1:0][2*POS_W-1:0]         tog,
    output logic [NREGION*$clog2(NSEQ)-1:0]      ptr,
    output logic [NREGION-1:0][POS_W-1:0]        cpos
);
    localparam int SEL_W   = $clog2(NSEQ);
    localparam int PTR_W   = NREGION * SEL_W;
    localparam int TOG_W   = 2 * POS_W;
    localparam int OFS_PTR = NSEQ + 1;
    localparam int OFS_R0  = NSEQ + NREGION + 1;

    logic [NSEQ-1:0]                  pol_q;
    logic [NSEQ-1:0][TOG_W-1:0]       tog_q;
    logic [PTR_W-1:0]                 ptr_q;
    logic [NREGION-1:1][POS_W-1:0]    cp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q <= '1;
            ptr_q <= '0;
            for (int s = 0; s < NSEQ; s++) tog_q[s] <= '1;
            for (int r = 1; r < NREGION; r++) cp_q[r] <= '1;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(BASE)) pol_q <= wr_data[NSEQ-1:0];
            if (wr_addr == ADDR_W'(BASE + OFS_PTR)) ptr_q <= wr_data[PTR_W-1:0];
            for (int s = 0; s < NSEQ; s++)
                if (wr_addr == ADDR_W'(BASE + 1 + s)) tog_q[s] <= wr_data[TOG_W-1:0];
            for (int r = 1; r < NREGION; r++)
                if (wr_addr == ADDR_W'(BASE + OFS_PTR + r)) cp_q[r] <= wr_data[POS_W-1:0];
        end
    end

    assign pol  = pol_q;
    assign tog  = tog_q;
    assign ptr  = ptr_q;
    assign cpos = {cp_q, POS_W'(0)};

    // R10: the fixed region-0 slot swallows writes
    assert_r0_slot_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(BASE + OFS_R0))
        |=> ($stable(pol_q) && $stable(ptr_q) && $stable(tog_q) && $stable(cp_q)));

    // R2: polarity lands at offset 0
    assert_pol_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(BASE)) |=> (pol_q == $past(wr_data[NSEQ-1:0])));

endmodule

// File: rtl/lpsg_timing.sv
module lpsg_timing
    import lpsg_pkg::*;
#(
    parameter int POS_W  = 12,
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync,
    input  logic              vsync,
    output logic [POS_W-1:0]  pix,
    output logic [LINE_W-1:0] line_nxt,
    output logic              run
);
    localparam logic [POS_W-1:0]  PIX_MAX  = '1;
    localparam logic [LINE_W-1:0] LINE_MAX = '1;

    line_state_e       state_q, state_d;
    logic [POS_W-1:0]  pix_q;
    logic [LINE_W-1:0] line_q;
    logic              cnt_en;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (hsync) state_d = ST_RUN;
            ST_RUN:     if (hsync) state_d = ST_RUN;
                        else if (pix_q == PIX_MAX) state_d = ST_OVERRUN;
            ST_OVERRUN: if (hsync) state_d = ST_RUN;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state outputs
    always_comb begin
        run    = (state_q == ST_RUN);
        cnt_en = (state_q == ST_RUN) && (pix_q != PIX_MAX);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      pix_q <= '0;
        else if (hsync)  pix_q <= '0;
        else if (cnt_en) pix_q <= pix_q + 1'b1;
    end

    always_comb begin
        if (vsync)      line_nxt = '0;
        else if (hsync) line_nxt = (line_q == LINE_MAX) ? line_q : line_q + 1'b1;
        else            line_nxt = line_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_nxt;
    end

    assign pix = pix_q;

    assert_pix_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hsync |=> (pix_q == '0));
    assert_pix_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !hsync && pix_q != PIX_MAX) |=> (pix_q == $past(pix_q) + 1'b1));
    assert_vsync_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |=> (line_q == '0));
    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (pix_q == '0));

endmodule

// File: rtl/lpsg_channel.sv
module lpsg_channel #(
    parameter int POS_W   = 12,
    parameter int LINE_W  = 12,
    parameter int NSEQ    = 4,
    parameter int NREGION = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 hsync,
    input  logic                                 run,
    input  logic [POS_W-1:0]                     pix,
    input  logic [LINE_W-1:0]                    line_nxt,
    input  logic [NSEQ-1:0]                      pol,
    input  logic [NSEQ-1:0][2*POS_W-1:0]         tog,
    input  logic [NREGION*$clog2(NSEQ)-1:0]      ptr,
    input  logic [NREGION-1:0][POS_W-1:0]        cpos,
    output logic                                 pulse
);
    localparam int SEL_W = $clog2(NSEQ);
    localparam int REG_W = $clog2(NREGION);
    localparam logic [POS_W-1:0] DIS = '1;

    logic [REG_W-1:0] reg_idx;
    logic [SEL_W-1:0] sel;
    logic [POS_W-1:0] t1_q, t2_q;
    logic             pulse_q, hit1, hit2;

    // highest region whose boundary has been reached
    always_comb begin
        reg_idx = '0;
        for (int r = 1; r < NREGION; r++)
            if (LINE_W'(cpos[r]) <= line_nxt) reg_idx = REG_W'(r);
        sel = ptr[reg_idx*SEL_W +: SEL_W];
    end

    assign hit1 = run && (t1_q != DIS) && (pix == t1_q);
    assign hit2 = run && (t2_q != DIS) && (pix == t2_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b1;
            t1_q    <= DIS;
            t2_q    <= DIS;
        end else if (hsync) begin
            pulse_q <= pol[sel];
            t1_q    <= tog[sel][POS_W-1:0];
            t2_q    <= tog[sel][2*POS_W-1:POS_W];
        end else if (hit1 ^ hit2) begin
            pulse_q <= ~pulse_q;
        end
    end

    assign pulse = pulse_q;

    assert_hold_outside_run_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!hsync && !run) |=> $stable(pulse_q));
    assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!hsync && t1_q == DIS && t2_q == DIS) |=> $stable(pulse_q));
    assert_equal_cancel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!hsync && t1_q == t2_q) |=> $stable(pulse_q));

endmodule

// File: rtl/line_pulse_seq_gen.sv
module line_pulse_seq_gen #(
    parameter int ADDR_W     = 6,
    parameter int DATA_W     = 24,
    parameter int POS_W      = 12,
    parameter int LINE_W     = 12,
    parameter int NSEQ       = 4,
    parameter int NREGION    = 4,
    parameter int CLAMP_BASE = 20,
    parameter int BLANK_BASE = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync,
    input  logic              vsync,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              clamp_pulse,
    output logic              blank_pulse
);
    localparam int NCH   = 2;
    localparam int PTR_W = NREGION * $clog2(NSEQ);

    logic [POS_W-1:0]  pix;
    logic [LINE_W-1:0] line_nxt;
    logic              run;
    logic [NCH-1:0]    pulse_w;

    lpsg_timing #(.POS_W(POS_W), .LINE_W(LINE_W)) u_timing (
        .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
        .pix(pix), .line_nxt(line_nxt), .run(run)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        localparam int B = (ch == 0) ? CLAMP_BASE : BLANK_BASE;
        logic [NSEQ-1:0]                 pol;
        logic [NSEQ-1:0][2*POS_W-1:0]    tog;
        logic [PTR_W-1:0]                ptr;
        logic [NREGION-1:0][POS_W-1:0]   cpos;

        lpsg_regfile #(
            .ADDR_W(ADDR_W), .DATA_W(DATA_W), .POS_W(POS_W),
            .NSEQ(NSEQ), .NREGION(NREGION), .BASE(B)
        ) u_regs (
            .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
            .wr_data(wr_data), .pol(pol), .tog(tog), .ptr(ptr), .cpos(cpos)
        );

        lpsg_channel #(
            .POS_W(POS_W), .LINE_W(LINE_W), .NSEQ(NSEQ), .NREGION(NREGION)
        ) u_chan (
            .clk(clk), .rst_n(rst_n), .hsync(hsync), .run(run), .pix(pix),
            .line_nxt(line_nxt), .pol(pol), .tog(tog), .ptr(ptr), .cpos(cpos),
            .pulse(pulse_w[ch])
        );
    end

    assign clamp_pulse = pulse_w[0];
    assign blank_pulse = pulse_w[1];

endmodule

// File: tb/line_pulse_seq_gen_test.sv
module line_pulse_seq_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hsync = 1'b0, vsync = 1'b0, wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [23:0] wr_data = '0;
    logic        clamp_pulse, blank_pulse;

    int nvec = 0, nfail = 0;
    int m_pol [2];
    int m_ptr [2];
    int m_tog [2][4];
    int m_cp  [2][4];
    int mline = 0;

    always #2 clk = ~clk;

    line_pulse_seq_gen uut (
        .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .clamp_pulse(clamp_pulse), .blank_pulse(blank_pulse)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        mline = 0;
        for (int c = 0; c < 2; c++) begin
            m_pol[c] = 'hF; m_ptr[c] = 0; m_cp[c][0] = 0;
            for (int s = 0; s < 4; s++) m_tog[c][s] = 'hFFFFFF;
            for (int r = 1; r < 4; r++) m_cp[c][r] = 'hFFF;
        end
    endtask

    // register map per R2; offset +9 and unmapped addresses ignored (R10)
    task automatic model_wr(input int a, input int d);
        for (int c = 0; c < 2; c++) begin
            int b = 20 + 10 * c;
            if (a == b) m_pol[c] = d & 'hF;
            else if (a >= b + 1 && a <= b + 4) m_tog[c][a-b-1] = d & 'hFFFFFF;
            else if (a == b + 5) m_ptr[c] = d & 'hFF;
            else if (a >= b + 6 && a <= b + 8) m_cp[c][a-b-5] = d & 'hFFF;
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 6'(a); wr_data = 24'(d);
        @(negedge clk);
        wr_en = 1'b0;
        model_wr(a, d);
    endtask

    function automatic int exp_level(input int st, input int t1, input int t2, input int k);
        int pk = (k > 4095) ? 4095 : k;
        int lv = st;
        if (t1 != 'hFFF && t1 < pk) lv ^= 1;
        if (t2 != 'hFFF && t2 < pk) lv ^= 1;
        return lv;
    endfunction

    // one line: optional coincident vsync, optional write at pixel wk
    task automatic run_line(input string req, input int n, input bit vs,
                            input int wk, input int wa, input int wd);
        int st[2], t1[2], t2[2], bad[2], badk[2], bada[2], bade[2];
        @(negedge clk);
        hsync = 1'b1; vsync = vs;
        mline = vs ? 0 : ((mline == 4095) ? 4095 : mline + 1);
        for (int c = 0; c < 2; c++) begin
            int rg = 0, sl;
            for (int r = 1; r < 4; r++) if (m_cp[c][r] <= mline) rg = r;
            sl = (m_ptr[c] >> (2 * rg)) & 3;
            st[c] = (m_pol[c] >> sl) & 1;
            t1[c] = m_tog[c][sl] & 'hFFF;
            t2[c] = (m_tog[c][sl] >> 12) & 'hFFF;
            bad[c] = 0;
        end
        @(negedge clk);
        hsync = 1'b0; vsync = 1'b0;
        for (int k = 0; k < n; k++) begin
            for (int c = 0; c < 2; c++) begin
                int act = (c == 0) ? int'(clamp_pulse) : int'(blank_pulse);
                int e = exp_level(st[c], t1[c], t2[c], k);
                if (act != e && !bad[c]) begin
                    bad[c] = 1; badk[c] = k; bada[c] = act; bade[c] = e;
                end
            end
            if (k == wk) begin wr_en = 1'b1; wr_addr = 6'(wa); wr_data = 24'(wd); end
            if (k == wk + 1) wr_en = 1'b0;
            @(negedge clk);
        end
        wr_en = 1'b0;
        if (wk >= 0) model_wr(wa, wd);
        for (int c = 0; c < 2; c++) begin
            if (bad[c])
                $display("FAIL detail %s ch%0d line %0d pixel %0d", req, c, mline, badk[c]);
            check(!bad[c], req, bad[c] ? bada[c] : 0, bad[c] ? bade[c] : 0);
        end
    endtask

    task automatic t_reset();
        check(clamp_pulse == 1'b1, "R1 clamp after reset", int'(clamp_pulse), 1);
        check(blank_pulse == 1'b1, "R1 blank after reset", int'(blank_pulse), 1);
        wr(20, 'h0);
        wr(30, 'h0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(clamp_pulse == 1'b1 && blank_pulse == 1'b1, "R12 idle hold",
                  int'({clamp_pulse, blank_pulse}), 3);
        end
        wr(30, 'hF);
        run_line("R1 default line", 48, 1'b1, -1, 0, 0);
    endtask

    task automatic t_basic();
        wr(21, (20 << 12) | 5);
        wr(31, (30 << 12) | 0);
        run_line("R3 toggle timing", 48, 1'b0, -1, 0, 0);
        wr(21, (3 << 12) | 40);
        wr(20, 'hF);
        run_line("R4 reversed order", 48, 1'b0, -1, 0, 0);
        wr(31, (17 << 12) | 1);
        run_line("R11 independent", 48, 1'b0, -1, 0, 0);
    endtask

    task automatic t_equal();
        wr(21, (9 << 12) | 9);
        wr(31, (9 << 12) | 8);
        run_line("R4 equal cancel", 48, 1'b0, -1, 0, 0);
    endtask

    task automatic t_disable();
        wr(21, ('hFFF << 12) | 7);
        wr(31, (12 << 12) | 'hFFF);
        run_line("R5 disabled pos", 48, 1'b0, -1, 0, 0);
    endtask

    task automatic t_regions();
        wr(22, (15 << 12) | 2);  wr(23, (25 << 12) | 11); wr(24, (33 << 12) | 4);
        wr(20, 'h5); wr(25, 'hE4); wr(26, 2); wr(27, 4); wr(28, 4);
        wr(32, (32 << 12) | 1);  wr(33, (33 << 12) | 3);  wr(34, (34 << 12) | 6);
        wr(30, 'hA); wr(35, 'h1B); wr(36, 1); wr(37, 3); wr(38, 5);
        run_line("R6 R7 line0", 48, 1'b1, -1, 0, 0);
        for (int i = 1; i < 7; i++) run_line("R7 R8 region line", 48, 1'b0, -1, 0, 0);
    endtask

    task automatic t_midwrite();
        run_line("R9 mid-line write", 48, 1'b0, 10, 25, 0);
        run_line("R9 next line", 48, 1'b0, -1, 0, 0);
    endtask

    task automatic t_ignored();
        wr(25, 'hE4);
        run_line("R10 setup", 48, 1'b1, -1, 0, 0);
        wr(29, 0); wr(39, 0); wr(10, 0); wr(63, 'hFFFFFF); wr(0, 0);
        run_line("R10 ignored writes", 48, 1'b1, -1, 0, 0);
    endtask

    task automatic t_vsync();
        run_line("R6 pre", 48, 1'b0, -1, 0, 0);
        run_line("R6 pre", 48, 1'b0, -1, 0, 0);
        @(negedge clk); vsync = 1'b1;
        @(negedge clk); vsync = 1'b0;
        mline = 0;
        run_line("R6 vsync alone", 48, 1'b0, -1, 0, 0);
    endtask

    task automatic t_overrun();
        wr(25, 0); wr(21, ('hFFF << 12) | 4094);
        wr(35, 0); wr(31, (4094 << 12) | 4093);
        run_line("R12 saturate", 4200, 1'b1, -1, 0, 0);
        run_line("R3 after overrun", 48, 1'b0, -1, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_equal();
        t_disable();
        t_regions();
        t_midwrite();
        t_ignored();
        t_vsync();
        t_overrun();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule